// File: doc/BRIEF.md
# Trap Entry State-Save Unit

This block performs the register bookkeeping a processor core needs at the moment it accepts a trap. The core presents a one-cycle request strobe with the 9-bit trap type, a delivery-mode select, and its current architectural state. That state is the trap level, the global-register level, the condition codes, the address-space identifier, the processor-state and hyper-state words, the current window pointer, the free-window count, and both program counters.

One clock edge later the unit raises the trap level. It fills the saved-state entry for the new level: a packed state word, both program counters, the hyper-state word and the trap type. It also presents the edited global level, processor state, hyper state and window pointer on its outputs, and pulses a completion strobe. If the core is already at the deepest supported level, the unit changes nothing and pulses an error strobe instead.

A read port selects any trap level and returns its saved entry combinationally. Deciding which trap wins, computing the handler address and returning from a trap are left to neighbouring logic.

Top module: `trap_entry_unit`

## Requirements
- R1: A request taken below the maximum level produces `done` high for exactly the one cycle after the strobe, with `new_tl` equal to the requesting level plus one. With no request, `done` stays low and every `new_*` output holds its value.
- R2: A request made with `cur_tl` at or above `MAXTL` pulses `tl_err` in the following cycle instead of `done`. The `new_*` outputs and every saved level keep their previous contents.
- R3: The saved state word of the new level packs the fields as follows: global level in bits 42:40, condition codes in 39:32, address-space identifier in 31:24, processor state in 20:8, window pointer zero-extended in 4:0. All other bits are zero.
- R4: The new level also saves the current PC, the current NPC, the current 12-bit hyper-state word and the 9-bit trap type.
- R5: `new_gl` is the current global level plus one, capped at `MAXGL`.
- R6: Privileged delivery (`hyp_mode`=0) edits the processor state as follows: bit 4 set, bit 3 cleared, bit 2 set, bit 1 cleared, bit 9 copied from bit 8. All other bits pass through, and the hyper-state word passes through unchanged.
- R7: Hyperprivileged delivery (`hyp_mode`=1) edits the hyper state: bit 5 cleared, bit 2 set, bit 10 cleared, all else kept. It also edits the processor state: bit 4 set, bits 3, 2, 1 and 9 cleared, all else kept.
- R8: Trap type 0x024 gives `new_cwp` = (CWP+1) mod `NWIN`.
- R9: Trap types 0x080 to 0x0BF give `new_cwp` = (CWP+CANSAVE+2) mod `NWIN`.
- R10: Trap types 0x0C0 to 0x0FF give `new_cwp` = (CWP-1) mod `NWIN`. Every other type leaves the window pointer unchanged.
- R11: After reset, `done` and `tl_err` are low, all `new_*` outputs are zero, and every saved level reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request strobe |
| trap_type | input | 9 | Type code of the trap being taken |
| hyp_mode | input | 1 | 1 = hyperprivileged delivery, 0 = privileged |
| cur_tl | input | TL_W (3) | Current trap level |
| cur_gl | input | 3 | Current global-register level |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 13 | Current processor-state word |
| cur_hpstate | input | 12 | Current hyper-state word |
| cur_cwp | input | CWP_W (3) | Current window pointer |
| cur_cansave | input | CWP_W (3) | Current count of saveable windows |
| cur_pc | input | PC_W (64) | Current program counter |
| cur_npc | input | PC_W (64) | Current next program counter |
| rd_lvl | input | TL_W (3) | Level selected on the read port |
| done | output | 1 | Trap committed this cycle |
| tl_err | output | 1 | Request refused because the level is at maximum |
| new_tl | output | TL_W (3) | Trap level after entry |
| new_gl | output | 3 | Global level after entry |
| new_pstate | output | 13 | Processor state after entry |
| new_hpstate | output | 12 | Hyper state after entry |
| new_cwp | output | CWP_W (3) | Window pointer after entry |
| rd_tstate | output | 64 | Saved state word of the selected level |
| rd_tpc | output | PC_W (64) | Saved PC of the selected level |
| rd_tnpc | output | PC_W (64) | Saved NPC of the selected level |
| rd_htstate | output | 12 | Saved hyper state of the selected level |
| rd_tt | output | 9 | Saved trap type of the selected level |

## Verification
The bench builds the unit with `NWIN`=6, `MAXTL`=3 and `MAXGL`=2. A window count that is not a power of two makes every modulo wrap a real subtraction rather than a dropped carry. The case CWP=5 with CANSAVE=5 reaches the largest spill sum, which lands exactly on twice the window count. A shallow level limit means random traps hit the refusal path often, so the bench can confirm that every saved level survives it. A low global cap exercises GL saturation as well.

// File: rtl/trap_entry_pkg.sv
`timescale 1ns/1ps
package trap_entry_pkg;
  localparam int TT_W  = 9;
  localparam int GL_W  = 3;
  localparam int CCR_W = 8;
  localparam int ASI_W = 8;
  localparam int PS_W  = 13;
  localparam int HPS_W = 12;
  localparam int TS_W  = 64;

  // processor-state bit positions
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;
  // hyper-state bit positions
  localparam int HP_HPRIV = 2;
  localparam int HP_RED   = 5;
  localparam int HP_IBE   = 10;

  typedef enum logic [1:0] {WIN_KEEP, WIN_INC, WIN_SPILL, WIN_DEC} win_op_e;

  function automatic win_op_e win_op_of(input logic [TT_W-1:0] tt);
    if (tt == 9'h024)                         return WIN_INC;
    else if (tt >= 9'h080 && tt <= 9'h0BF)    return WIN_SPILL;
    else if (tt >= 9'h0C0 && tt <= 9'h0FF)    return WIN_DEC;
    else                                      return WIN_KEEP;
  endfunction
endpackage

// File: rtl/trap_cwp_adj.sv
`timescale 1ns/1ps
module trap_cwp_adj
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic [TT_W-1:0]  tt,
  input  logic [CWP_W-1:0] cwp,
  input  logic [CWP_W-1:0] cansave,
  output logic [CWP_W-1:0] cwp_nxt
);
  localparam int SW = CWP_W + 2;
  localparam logic [SW-1:0] WIN1 = SW'(NWIN);
  localparam logic [SW-1:0] WIN2 = SW'(2 * NWIN);

  win_op_e         op;
  logic [SW-1:0]   sum;
  logic [SW-1:0]   red;

  always_comb begin
    op = win_op_of(tt);
    case (op)
      WIN_INC:   sum = SW'(cwp) + SW'(1);
      WIN_SPILL: sum = SW'(cwp) + SW'(cansave) + SW'(2);
      WIN_DEC:   sum = SW'(cwp) + WIN1 - SW'(1);
      default:   sum = SW'(cwp);
    endcase
    // largest sum is 2*NWIN, so two conditional subtractions suffice
    if (sum >= WIN2)      red = sum - WIN2;
    else if (sum >= WIN1) red = sum - WIN1;
    else                  red = sum;
    cwp_nxt = red[CWP_W-1:0];
  end
endmodule

// File: rtl/trap_state_edit.sv
`timescale 1ns/1ps
module trap_state_edit
  import trap_entry_pkg::*;
#(
  parameter int MAXGL = 3
) (
  input  logic             hyp,
  input  logic [GL_W-1:0]  gl,
  input  logic [PS_W-1:0]  pstate,
  input  logic [HPS_W-1:0] hpstate,
  output logic [GL_W-1:0]  gl_nxt,
  output logic [PS_W-1:0]  pstate_nxt,
  output logic [HPS_W-1:0] hpstate_nxt
);
  localparam logic [GL_W-1:0] GL_TOP = GL_W'(MAXGL);

  always_comb begin
    gl_nxt = (gl >= GL_TOP) ? GL_TOP : gl + GL_W'(1);

    pstate_nxt         = pstate;
    pstate_nxt[PS_PEF] = 1'b1;
    pstate_nxt[PS_AM]  = 1'b0;
    pstate_nxt[PS_IE]  = 1'b0;
    if (hyp) begin
      pstate_nxt[PS_PRIV] = 1'b0;
      pstate_nxt[PS_CLE]  = 1'b0;
    end else begin
      pstate_nxt[PS_PRIV] = 1'b1;
      pstate_nxt[PS_CLE]  = pstate[PS_TLE];
    end

    hpstate_nxt = hpstate;
    if (hyp) begin
      hpstate_nxt[HP_RED]   = 1'b0;
      hpstate_nxt[HP_HPRIV] = 1'b1;
      hpstate_nxt[HP_IBE]   = 1'b0;
    end
  end
endmodule

// File: rtl/trap_save_bank.sv
`timescale 1ns/1ps
module trap_save_bank
  import trap_entry_pkg::*;
#(
  parameter int MAXTL = 6,
  parameter int PC_W  = 64,
  parameter int TL_W  = $clog2(MAXTL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TL_W-1:0]  wr_lvl,
  input  logic [TS_W-1:0]  wr_tstate,
  input  logic [PC_W-1:0]  wr_tpc,
  input  logic [PC_W-1:0]  wr_tnpc,
  input  logic [HPS_W-1:0] wr_htstate,
  input  logic [TT_W-1:0]  wr_tt,
  input  logic [TL_W-1:0]  rd_lvl,
  output logic [TS_W-1:0]  rd_tstate,
  output logic [PC_W-1:0]  rd_tpc,
  output logic [PC_W-1:0]  rd_tnpc,
  output logic [HPS_W-1:0] rd_htstate,
  output logic [TT_W-1:0]  rd_tt
);
  localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAXTL);

  logic [TS_W-1:0]  ts_lv [0:MAXTL];
  logic [PC_W-1:0]  pc_lv [0:MAXTL];
  logic [PC_W-1:0]  npc_lv[0:MAXTL];
  logic [HPS_W-1:0] hs_lv [0:MAXTL];
  logic [TT_W-1:0]  tt_lv [0:MAXTL];

  // level 0 holds no saved state
  assign ts_lv[0]  = '0;
  assign pc_lv[0]  = '0;
  assign npc_lv[0] = '0;
  assign hs_lv[0]  = '0;
  assign tt_lv[0]  = '0;

  for (genvar g = 1; g <= MAXTL; g++) begin : g_lvl
    logic [TS_W-1:0]  ts_q;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  npc_q;
    logic [HPS_W-1:0] hs_q;
    logic [TT_W-1:0]  tt_q;
    logic             en;

    assign en = wr_en && (wr_lvl == TL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ts_q  <= '0;
        pc_q  <= '0;
        npc_q <= '0;
        hs_q  <= '0;
        tt_q  <= '0;
      end else if (en) begin
        ts_q  <= wr_tstate;
        pc_q  <= wr_tpc;
        npc_q <= wr_tnpc;
        hs_q  <= wr_htstate;
        tt_q  <= wr_tt;
      end
    end

    assign ts_lv[g]  = ts_q;
    assign pc_lv[g]  = pc_q;
    assign npc_lv[g] = npc_q;
    assign hs_lv[g]  = hs_q;
    assign tt_lv[g]  = tt_q;
  end

  always_comb begin
    rd_tstate  = '0;
    rd_tpc     = '0;
    rd_tnpc    = '0;
    rd_htstate = '0;
    rd_tt      = '0;
    for (int i = 0; i <= MAXTL; i++) begin
      if (rd_lvl == TL_W'(i)) begin
        rd_tstate  = ts_lv[i];
        rd_tpc     = pc_lv[i];
        rd_tnpc    = npc_lv[i];
        rd_htstate = hs_lv[i];
        rd_tt      = tt_lv[i];
      end
    end
  end

  // a write always targets a real level, never level 0 or beyond the top
  assert_wr_level_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_lvl != '0 && wr_lvl <= TL_TOP));

  // R3: a written level reads back the word presented at the write
  assert_tstate_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_lvl == wr_lvl) |=> (rd_lvl != $past(rd_lvl)) || (rd_tstate == $past(wr_tstate)));
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int MAXTL = 6,
  parameter int MAXGL = 3,
  parameter int PC_W  = 64,
  parameter int TL_W  = $clog2(MAXTL + 1),
  parameter int CWP_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [TT_W-1:0]  trap_type,
  input  logic             hyp_mode,
  input  logic [TL_W-1:0]  cur_tl,
  input  logic [GL_W-1:0]  cur_gl,
  input  logic [CCR_W-1:0] cur_ccr,
  input  logic [ASI_W-1:0] cur_asi,
  input  logic [PS_W-1:0]  cur_pstate,
  input  logic [HPS_W-1:0] cur_hpstate,
  input  logic [CWP_W-1:0] cur_cwp,
  input  logic [CWP_W-1:0] cur_cansave,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [PC_W-1:0]  cur_npc,
  input  logic [TL_W-1:0]  rd_lvl,
  output logic             done,
  output logic             tl_err,
  output logic [TL_W-1:0]  new_tl,
  output logic [GL_W-1:0]  new_gl,
  output logic [PS_W-1:0]  new_pstate,
  output logic [HPS_W-1:0] new_hpstate,
  output logic [CWP_W-1:0] new_cwp,
  output logic [TS_W-1:0]  rd_tstate,
  output logic [PC_W-1:0]  rd_tpc,
  output logic [PC_W-1:0]  rd_tnpc,
  output logic [HPS_W-1:0] rd_htstate,
  output logic [TT_W-1:0]  rd_tt
);
  localparam logic [TL_W-1:0]  TL_TOP = TL_W'(MAXTL);
  localparam logic [GL_W-1:0]  GL_TOP = GL_W'(MAXGL);
  localparam logic [CWP_W-1:0] CW_TOP = CWP_W'(NWIN - 1);

  // next-state signals
  logic             at_top;
  logic             take;
  logic             refuse;
  logic [TL_W-1:0]  tl_d;
  logic [GL_W-1:0]  gl_d;
  logic [PS_W-1:0]  ps_d;
  logic [HPS_W-1:0] hps_d;
  logic [CWP_W-1:0] cwp_d;
  logic [TS_W-1:0]  tstate_d;

  trap_cwp_adj #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
    .tt(trap_type), .cwp(cur_cwp), .cansave(cur_cansave), .cwp_nxt(cwp_d)
  );

  trap_state_edit #(.MAXGL(MAXGL)) u_edit (
    .hyp(hyp_mode), .gl(cur_gl), .pstate(cur_pstate), .hpstate(cur_hpstate),
    .gl_nxt(gl_d), .pstate_nxt(ps_d), .hpstate_nxt(hps_d)
  );

  always_comb begin
    at_top   = (cur_tl >= TL_TOP);
    take     = trap_req && !at_top;
    refuse   = trap_req && at_top;
    tl_d     = cur_tl + TL_W'(1);
    tstate_d = '0;
    tstate_d[42:40] = cur_gl;
    tstate_d[39:32] = cur_ccr;
    tstate_d[31:24] = cur_asi;
    tstate_d[20:8]  = cur_pstate;
    tstate_d[4:0]   = 5'(cur_cwp);
  end

  trap_save_bank #(.MAXTL(MAXTL), .PC_W(PC_W), .TL_W(TL_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(take), .wr_lvl(tl_d), .wr_tstate(tstate_d),
    .wr_tpc(cur_pc), .wr_tnpc(cur_npc), .wr_htstate(cur_hpstate), .wr_tt(trap_type),
    .rd_lvl(rd_lvl),
    .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc),
    .rd_htstate(rd_htstate), .rd_tt(rd_tt)
  );

  // strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      tl_err <= 1'b0;
    end else begin
      done   <= take;
      tl_err <= refuse;
    end
  end

  // architectural outputs, enabled by an accepted trap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_tl      <= '0;
      new_gl      <= '0;
      new_pstate  <= '0;
      new_hpstate <= '0;
      new_cwp     <= '0;
    end else if (take) begin
      new_tl      <= tl_d;
      new_gl      <= gl_d;
      new_pstate  <= ps_d;
      new_hpstate <= hps_d;
      new_cwp     <= cwp_d;
    end
  end

  assert_tl_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_tl == $past(cur_tl) + TL_W'(1)));

  assert_req_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (done || tl_err));

  assert_err_only_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tl_err |-> ($past(cur_tl) >= TL_TOP) && !done);

  assert_hold_on_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tl_err |-> ($stable(new_tl) && $stable(new_gl) && $stable(new_cwp)));

  assert_gl_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_gl <= GL_TOP));

  assert_priv_edit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(hyp_mode)) |-> (new_pstate[PS_PRIV] && !new_pstate[PS_IE]
                                    && new_hpstate == $past(cur_hpstate)));

  assert_hyp_edit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(hyp_mode)) |-> (new_hpstate[HP_HPRIV] && !new_hpstate[HP_RED]
                                   && !new_pstate[PS_PRIV]));

  assert_cwp_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_cwp <= CW_TOP));
endmodule

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;
  localparam int NWIN  = 6;
  localparam int MAXTL = 3;
  localparam int MAXGL = 2;
  localparam int PC_W  = 64;
  localparam int TL_W  = $clog2(MAXTL + 1);
  localparam int CWP_W = $clog2(NWIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0;
  logic [8:0] trap_type = '0;
  logic hyp_mode = 1'b0;
  logic [TL_W-1:0] cur_tl = '0;
  logic [2:0] cur_gl = '0;
  logic [7:0] cur_ccr = '0, cur_asi = '0;
  logic [12:0] cur_pstate = '0;
  logic [11:0] cur_hpstate = '0;
  logic [CWP_W-1:0] cur_cwp = '0, cur_cansave = '0;
  logic [PC_W-1:0] cur_pc = '0, cur_npc = '0;
  logic [TL_W-1:0] rd_lvl = '0;
  logic done, tl_err;
  logic [TL_W-1:0] new_tl;
  logic [2:0] new_gl;
  logic [12:0] new_pstate;
  logic [11:0] new_hpstate;
  logic [CWP_W-1:0] new_cwp;
  logic [63:0] rd_tstate;
  logic [PC_W-1:0] rd_tpc, rd_tnpc;
  logic [11:0] rd_htstate;
  logic [8:0] rd_tt;

  trap_entry_unit #(.NWIN(NWIN), .MAXTL(MAXTL), .MAXGL(MAXGL), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .hyp_mode(hyp_mode), .cur_tl(cur_tl), .cur_gl(cur_gl), .cur_ccr(cur_ccr),
    .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_hpstate(cur_hpstate),
    .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .rd_lvl(rd_lvl), .done(done), .tl_err(tl_err), .new_tl(new_tl), .new_gl(new_gl),
    .new_pstate(new_pstate), .new_hpstate(new_hpstate), .new_cwp(new_cwp),
    .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc),
    .rd_htstate(rd_htstate), .rd_tt(rd_tt)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of expected outputs and saved levels
  logic [TL_W-1:0] e_tl = '0;
  logic [2:0] e_gl = '0;
  logic [12:0] e_ps = '0;
  logic [11:0] e_hps = '0;
  logic [CWP_W-1:0] e_cwp = '0;
  logic [63:0] s_ts [0:MAXTL];
  logic [63:0] s_pc [0:MAXTL];
  logic [63:0] s_npc[0:MAXTL];
  logic [11:0] s_hs [0:MAXTL];
  logic [8:0]  s_tt [0:MAXTL];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] f_pack(input logic [2:0] gl, input logic [7:0] ccr,
      input logic [7:0] asi, input logic [12:0] ps, input logic [CWP_W-1:0] cwp);
    logic [63:0] w = '0;
    w[42:40] = gl; w[39:32] = ccr; w[31:24] = asi; w[20:8] = ps; w[4:0] = 5'(cwp);
    return w;
  endfunction

  function automatic logic [12:0] f_ps(input logic [12:0] ps, input logic hyp);
    logic [12:0] r = ps;
    r[4] = 1'b1; r[3] = 1'b0; r[1] = 1'b0;
    if (hyp) begin r[2] = 1'b0; r[9] = 1'b0; end
    else     begin r[2] = 1'b1; r[9] = ps[8]; end
    return r;
  endfunction

  function automatic logic [11:0] f_hps(input logic [11:0] h, input logic hyp);
    logic [11:0] r = h;
    if (hyp) begin r[5] = 1'b0; r[2] = 1'b1; r[10] = 1'b0; end
    return r;
  endfunction

  function automatic logic [CWP_W-1:0] f_cwp(input logic [8:0] tt, input int cwp, input int cs);
    int v = cwp;
    if (tt == 9'h024) v = cwp + 1;
    else if (tt >= 9'h080 && tt <= 9'h0BF) v = cwp + cs + 2;
    else if (tt >= 9'h0C0 && tt <= 9'h0FF) v = cwp - 1 + NWIN;
    return CWP_W'(v % NWIN);
  endfunction

  task automatic check_levels(input string req);
    for (int l = 1; l <= MAXTL; l++) begin
      rd_lvl = TL_W'(l);
      #0.5;
      check(req, rd_tstate, s_ts[l]);
      check(req, rd_tpc, s_pc[l]);
      check(req, rd_tnpc, s_npc[l]);
      check(req, 64'(rd_htstate), 64'(s_hs[l]));
      check(req, 64'(rd_tt), 64'(s_tt[l]));
    end
  endtask

  task automatic run_trap(input logic [8:0] tt, input logic hyp, input int tl, input int gl,
      input int cwp, input int cs, input logic [12:0] ps, input string creq);
    int lv;
    @(negedge clk);
    trap_type = tt; hyp_mode = hyp; cur_tl = TL_W'(tl); cur_gl = 3'(gl);
    cur_ccr = 8'($urandom); cur_asi = 8'($urandom); cur_pstate = ps;
    cur_hpstate = 12'($urandom); cur_cwp = CWP_W'(cwp); cur_cansave = CWP_W'(cs);
    cur_pc = {$urandom, $urandom}; cur_npc = {$urandom, $urandom};
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    if (tl >= MAXTL) begin
      check("R2 err", 64'(tl_err), 64'd1);
      check("R2 done", 64'(done), 64'd0);
      check("R2 tl held", 64'(new_tl), 64'(e_tl));
      check("R2 gl held", 64'(new_gl), 64'(e_gl));
      check("R2 ps held", 64'(new_pstate), 64'(e_ps));
      check("R2 cwp held", 64'(new_cwp), 64'(e_cwp));
      check_levels("R2 levels kept");
    end else begin
      lv = tl + 1;
      e_tl = TL_W'(lv);
      e_gl = (gl >= MAXGL) ? 3'(MAXGL) : 3'(gl + 1);
      e_ps = f_ps(ps, hyp);
      e_hps = f_hps(cur_hpstate, hyp);
      e_cwp = f_cwp(tt, cwp, cs);
      s_ts[lv] = f_pack(3'(gl), cur_ccr, cur_asi, ps, CWP_W'(cwp));
      s_pc[lv] = cur_pc; s_npc[lv] = cur_npc; s_hs[lv] = cur_hpstate; s_tt[lv] = tt;
      check("R1 done", 64'(done), 64'd1);
      check("R1 no err", 64'(tl_err), 64'd0);
      check("R1 tl", 64'(new_tl), 64'(e_tl));
      check("R5 gl", 64'(new_gl), 64'(e_gl));
      check(hyp ? "R7 pstate" : "R6 pstate", 64'(new_pstate), 64'(e_ps));
      check(hyp ? "R7 hpstate" : "R6 hpstate", 64'(new_hpstate), 64'(e_hps));
      check(creq, 64'(new_cwp), 64'(e_cwp));
      check_levels("R3 R4 saved levels");
    end
    @(negedge clk);
    check("R1 single pulse", 64'(done), 64'd0);
    check("R1 outputs hold", 64'(new_tl), 64'(e_tl));
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int l = 0; l <= MAXTL; l++) begin
      s_ts[l] = '0; s_pc[l] = '0; s_npc[l] = '0; s_hs[l] = '0; s_tt[l] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 done", 64'(done), 64'd0);
    check("R11 err", 64'(tl_err), 64'd0);
    check("R11 tl", 64'(new_tl), 64'd0);
    check("R11 pstate", 64'(new_pstate), 64'd0);
    check("R11 cwp", 64'(new_cwp), 64'd0);
    check_levels("R11 levels zero");

    // directed corners
    run_trap(9'h024, 1'b0, 0, 0, 5, 0, 13'h0100, "R8 cwp wrap up");      // 5+1 -> 0
    run_trap(9'h0C0, 1'b0, 1, 1, 0, 2, 13'h1FFF, "R10 cwp wrap down");   // 0-1 -> 5
    run_trap(9'h0BF, 1'b1, 2, 2, 5, 5, 13'h0000, "R9 cwp spill max");    // 12 -> 0
    run_trap(9'h080, 1'b1, 0, 7, 4, 1, 13'h0ABC, "R9 cwp spill");        // 7 -> 1
    run_trap(9'h0FF, 1'b0, 0, 1, 3, 4, 13'h000F, "R10 cwp dec");
    run_trap(9'h100, 1'b0, 2, 0, 2, 3, 13'h0055, "R10 cwp keep");
    run_trap(9'h023, 1'b1, 1, 0, 4, 0, 13'h0155, "R10 cwp keep");
    run_trap(9'h024, 1'b0, 3, 0, 1, 0, 13'h0000, "R2 at top");
    run_trap(9'h0C0, 1'b1, 3, 1, 1, 0, 13'h0000, "R2 at top");

    // random traffic
    for (int k = 0; k < 300; k++) begin
      int sel = $urandom % 5;
      logic [8:0] tt;
      string rq;
      case (sel)
        0: begin tt = 9'h024; rq = "R8 cwp"; end
        1: begin tt = 9'h080 + 9'($urandom % 64); rq = "R9 cwp"; end
        2: begin tt = 9'h0C0 + 9'($urandom % 64); rq = "R10 cwp"; end
        default: begin tt = 9'($urandom); rq = "R8 R9 R10 cwp"; end
      endcase
      run_trap(tt, 1'($urandom), $urandom % (MAXTL + 1), $urandom % (MAXGL + 2),
               $urandom % NWIN, $urandom % NWIN, 13'($urandom), rq);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule